// File: doc/BRIEF.md
# Interleaved Memory Burst Controller

This block sits between a 32-bit processor port and a main memory built from four word-wide banks. A single direction bit marks each request. A 1 starts an eight-word block read and a 0 starts a single-word write. Memory uses low-order interleaving, so word addresses that follow one another land in banks that follow one another. A block read therefore issues one address cycle that starts all four banks at once. The four words then stream back on four consecutive transfer cycles.

A mode input selects a flat organisation for each request instead. In flat mode every word pays for its own address cycle and its own transfer cycle. This lets the two organisations be compared on the same hardware. When a request finishes, the block pulses a completion flag and stores the number of cycles the request used. Software or a testbench can read that count to estimate bandwidth. Each bank is modelled as a small synchronous array, and the array aliases inside its local address range.

Top module: `ilv_mem_ctrl`

## Requirements
- R1: A request is accepted on a rising clock edge where `req_valid` is 1 and `busy` is 0. At that edge `req_rd` (1 = block read, 0 = single-word write), `req_addr`, `req_wdata` and `interleave` are sampled. `req_addr` is a byte address.
- R2: A block read returns the eight words starting at the base word address, in ascending order. Each word is the value most recently written to that address, and each word appears on `rd_data` while `rd_valid` is 1.
- R3: An accepted read with `interleave` = 1 runs twice through this pattern: one address cycle (`busy` = 1, `rd_valid` = 0), then four transfer cycles (`rd_valid` = 1). That is 10 busy cycles in total.
- R4: An accepted read with `interleave` = 0 alternates one address cycle and one transfer cycle for each word. That is 16 busy cycles in total.
- R5: An accepted write spends one address cycle and then one transfer cycle. It stores the `req_wdata` sampled at acceptance into the addressed word. `rd_valid` stays 0 throughout.
- R6: A read whose byte address has a nonzero value in bits [4:0] is rejected. So is a write whose byte address has a nonzero value in bits [1:0]. A rejected request raises `err` for exactly the next cycle. It leaves `busy` and `done` low, changes no stored word and leaves `cycle_count` unchanged.
- R7: `done` is 1 for exactly the one cycle after the last transfer cycle, and `busy` is 0 in that cycle.
- R8: `cycle_count` takes the number of busy cycles of the finished request in the cycle where `done` is 1. It holds its value at all other times.
- R9: While `busy` is 1, `req_valid` and the other request inputs have no effect.
- R10: After reset, `busy`, `rd_valid`, `done` and `err` are 0 and `cycle_count` is 0.
- R11: Changing `interleave` while a request is in progress does not change the timing of that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_rd | input | 1 | Direction: 1 read block, 0 write word |
| req_addr | input | 31 | Byte address (2 GB space) |
| req_wdata | input | 32 | Write word |
| interleave | input | 1 | 1 = four-bank interleaved timing, 0 = flat timing |
| busy | output | 1 | Request in progress |
| rd_valid | output | 1 | Read word present on rd_data |
| rd_data | output | 32 | Read word |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle rejection pulse |
| cycle_count | output | 8 | Busy cycles of the last completed request |

## Verification
The bench builds the block with its defaults: four banks, eight-word bursts, 32-bit words and 16 modelled words per bank. With these values the 10-cycle interleaved read and the 16-cycle flat read both fit well inside the 8-bit counter. The 64 modelled words are also enough to hold several distinct bursts without aliasing. These defaults put the group boundary within reach, where the interleaved read must issue a second address cycle after bank 3. They also let the bench compare both timing modes on the same words, and show that a write ignored during a burst leaves word 0 intact.

// File: rtl/ilv_pkg.sv
// Shared types for the interleaved memory burst controller.
// Assumes: one sequencer state machine with idle, address and transfer phases.
package ilv_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_XFER = 2'd2
    } ilv_state_t;
endpackage

// File: rtl/ilv_bank.sv
// One word-wide memory bank model with a synchronous read register.
// Assumes: launch and wr_en are never high together. Only the low
// MODEL_AW bits of the local address select storage, so the array aliases.
module ilv_bank #(
    parameter int DATA_W   = 32,
    parameter int LOCAL_W  = 27,
    parameter int MODEL_AW = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               launch,
    input  logic               wr_en,
    input  logic [LOCAL_W-1:0] local_addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  q
);
    localparam int DEPTH = 1 << MODEL_AW;

    logic [DATA_W-1:0]   mem [DEPTH];
    logic [MODEL_AW-1:0] idx;

    // Fold the local address into the modelled depth.
    assign idx = MODEL_AW'(local_addr % LOCAL_W'(DEPTH));

    // Storage write port.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[idx] <= wdata;
        end
    end

    // Read register, loaded on the address cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (launch) begin
            q <= mem[idx];
        end
    end
endmodule

// File: rtl/ilv_seq.sv
// Request sequencer: accepts requests, checks alignment, steps the address
// and transfer phases, drives bank strobes and keeps the cycle counter.
// Assumes: NB and BURST_LEN are powers of two and BURST_LEN is a multiple of NB.
module ilv_seq
    import ilv_pkg::*;
#(
    parameter int ADDR_W    = 31,
    parameter int DATA_W    = 32,
    parameter int NB        = 4,
    parameter int BURST_LEN = 8,
    parameter int CNT_W     = 8
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 req_valid,
    input  logic                                 req_rd,
    input  logic [ADDR_W-1:0]                    req_addr,
    input  logic [DATA_W-1:0]                    req_wdata,
    input  logic                                 interleave,
    output logic                                 busy,
    output logic                                 rd_valid,
    output logic                                 done,
    output logic                                 err,
    output logic [CNT_W-1:0]                     cycle_count,
    output logic [NB-1:0]                        bank_launch,
    output logic [NB-1:0]                        bank_wr,
    output logic [ADDR_W-2-$clog2(NB)-1:0]       local_addr,
    output logic [$clog2(NB)-1:0]                word_bank,
    output logic [DATA_W-1:0]                    wdata_q
);
    localparam int WORD_AW  = ADDR_W - 2;
    localparam int BSEL_W   = $clog2(NB);
    localparam int IDX_W    = $clog2(BURST_LEN);
    localparam int RD_ALIGN = IDX_W + 2;

    ilv_state_t         state;
    logic               is_rd;
    logic               ilv_q;
    logic [WORD_AW-1:0] base_word;
    logic [IDX_W-1:0]   word_idx;
    logic [CNT_W-1:0]   cnt;
    logic [WORD_AW-1:0] cur_word;
    logic               misaligned;
    logic               last_beat;
    logic               grp_end;

    // Word currently addressed and its bank / local position.
    assign cur_word   = base_word + WORD_AW'(word_idx);
    assign word_bank  = cur_word[BSEL_W-1:0];
    assign local_addr = cur_word[WORD_AW-1:BSEL_W];

    // Alignment rule: whole burst for reads, whole word for writes.
    assign misaligned = req_rd ? (|req_addr[RD_ALIGN-1:0]) : (|req_addr[1:0]);
    assign last_beat  = !is_rd || (word_idx == IDX_W'(BURST_LEN - 1));
    assign grp_end    = !ilv_q || (word_bank == BSEL_W'(NB - 1));

    assign busy     = (state != ST_IDLE);
    assign rd_valid = (state == ST_XFER) && is_rd;

    // Bank strobes: all banks on an interleaved read address cycle, else one.
    always_comb begin
        for (int b = 0; b < NB; b++) begin
            bank_launch[b] = (state == ST_ADDR) &&
                             ((is_rd && ilv_q) || (word_bank == BSEL_W'(b)));
            bank_wr[b]     = (state == ST_XFER) && !is_rd &&
                             (word_bank == BSEL_W'(b));
        end
    end

    // Phase sequencing, completion flags and cycle counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            is_rd       <= 1'b0;
            ilv_q       <= 1'b0;
            base_word   <= '0;
            word_idx    <= '0;
            cnt         <= '0;
            cycle_count <= '0;
            done        <= 1'b0;
            err         <= 1'b0;
            wdata_q     <= '0;
        end else begin
            done <= 1'b0;
            err  <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        if (misaligned) begin
                            err <= 1'b1;
                        end else begin
                            state     <= ST_ADDR;
                            is_rd     <= req_rd;
                            ilv_q     <= interleave;
                            base_word <= req_addr[ADDR_W-1:2];
                            word_idx  <= '0;
                            cnt       <= '0;
                            wdata_q   <= req_wdata;
                        end
                    end
                end
                ST_ADDR: begin
                    state <= ST_XFER;
                    cnt   <= cnt + 1'b1;
                end
                ST_XFER: begin
                    cnt <= cnt + 1'b1;
                    if (last_beat) begin
                        state       <= ST_IDLE;
                        done        <= 1'b1;
                        cycle_count <= cnt + 1'b1;
                    end else begin
                        word_idx <= word_idx + 1'b1;
                        state    <= grp_end ? ST_ADDR : ST_XFER;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ilv_mem_ctrl.sv
// Top of the interleaved memory burst controller: sequencer, NB bank
// models and the read-return multiplexer.
// Assumes: byte addressing, 32-bit words, bank chosen by word address low bits.
module ilv_mem_ctrl #(
    parameter int ADDR_W    = 31,
    parameter int DATA_W    = 32,
    parameter int NB        = 4,
    parameter int BURST_LEN = 8,
    parameter int CNT_W     = 8,
    parameter int MODEL_AW  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_rd,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              interleave,
    output logic              busy,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              done,
    output logic              err,
    output logic [CNT_W-1:0]  cycle_count
);
    localparam int BSEL_W  = $clog2(NB);
    localparam int LOCAL_W = ADDR_W - 2 - BSEL_W;

    logic [NB-1:0]      bank_launch;
    logic [NB-1:0]      bank_wr;
    logic [LOCAL_W-1:0] local_addr;
    logic [BSEL_W-1:0]  word_bank;
    logic [DATA_W-1:0]  wdata_q;
    logic [DATA_W-1:0]  bank_q [NB];

    ilv_seq #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NB(NB),
        .BURST_LEN(BURST_LEN), .CNT_W(CNT_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_rd(req_rd), .req_addr(req_addr),
        .req_wdata(req_wdata), .interleave(interleave),
        .busy(busy), .rd_valid(rd_valid), .done(done), .err(err),
        .cycle_count(cycle_count),
        .bank_launch(bank_launch), .bank_wr(bank_wr),
        .local_addr(local_addr), .word_bank(word_bank), .wdata_q(wdata_q)
    );

    // One bank model per interleave way.
    for (genvar b = 0; b < NB; b++) begin : g_bank
        ilv_bank #(
            .DATA_W(DATA_W), .LOCAL_W(LOCAL_W), .MODEL_AW(MODEL_AW)
        ) u_bank (
            .clk(clk), .rst_n(rst_n),
            .launch(bank_launch[b]), .wr_en(bank_wr[b]),
            .local_addr(local_addr), .wdata(wdata_q),
            .q(bank_q[b])
        );
    end

    // Return the current word's bank register during read transfers.
    assign rd_data = rd_valid ? bank_q[word_bank] : '0;
endmodule

// File: rtl/ilv_mem_ctrl_chk.sv
// Assertion checker for ilv_mem_ctrl, attached through bind.
// Assumes: default write takes two busy cycles.
module ilv_mem_ctrl_chk #(
    parameter int NB        = 4,
    parameter int BURST_LEN = 8,
    parameter int CNT_W     = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             busy,
    input logic             rd_valid,
    input logic             done,
    input logic             err,
    input logic [CNT_W-1:0] cycle_count
);
    localparam int ILV_CYC  = (BURST_LEN / NB) * (NB + 1);
    localparam int FLAT_CYC = 2 * BURST_LEN;
    localparam int WR_CYC   = 2;

    // R1: busy only starts after a presented request.
    assert_start_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid));

    // R3: read words appear only while busy.
    assert_rv_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> busy);

    // R6: rejection is a lone one-cycle pulse.
    assert_err_alone_R6: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!busy && !done));
    assert_err_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> !err);

    // R7: completion is a one-cycle pulse outside the busy window.
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !rd_valid));

    // R8: counter moves only with done and only to a legal request length.
    assert_cc_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cycle_count) |-> done);
    assert_cc_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cycle_count == CNT_W'(ILV_CYC) || cycle_count == CNT_W'(FLAT_CYC)
                  || cycle_count == CNT_W'(WR_CYC)));
endmodule

bind ilv_mem_ctrl ilv_mem_ctrl_chk #(
    .NB(NB), .BURST_LEN(BURST_LEN), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .busy(busy),
    .rd_valid(rd_valid), .done(done), .err(err), .cycle_count(cycle_count)
);

// File: tb/ilv_mem_ctrl_tb.sv
`timescale 1ns/1ps
module ilv_mem_ctrl_tb;
    typedef struct packed {
        logic        busy;
        logic        rv;
        logic        dn;
        logic        er;
        logic [31:0] d;
        logic [7:0]  cc;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_rd = 1'b0;
    logic [30:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        interleave = 1'b0;
    logic        busy, rd_valid, done, err;
    logic [31:0] rd_data;
    logic [7:0]  cycle_count;

    int          n_chk = 0;
    int          n_err = 0;
    int          cyc = 0;
    bit          run = 1'b0;
    exp_t        q[$];
    logic [31:0] ref_mem [int];
    logic [7:0]  pred_cc = 8'd0;
    logic [7:0]  exp_cc = 8'd0;
    string       cur_req = "R10";

    always #2 clk = ~clk;

    ilv_mem_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_rd(req_rd),
        .req_addr(req_addr), .req_wdata(req_wdata), .interleave(interleave),
        .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data), .done(done),
        .err(err), .cycle_count(cycle_count)
    );

    task automatic chk(string rq, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    function automatic exp_t mk(logic b, logic rv, logic dn, logic er,
                                logic [31:0] d, logic [7:0] cc);
        exp_t e;
        e.busy = b; e.rv = rv; e.dn = dn; e.er = er; e.d = d; e.cc = cc;
        return e;
    endfunction

    // Per-cycle comparison against the behavioural expectation queue.
    always @(negedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=%0d expected<20000 cycles", cyc);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
        if (run) begin
            exp_t e;
            string rq;
            if (q.size() > 0) begin
                e = q.pop_front();
                exp_cc = e.cc;
                rq = cur_req;
            end else begin
                e = mk(1'b0, 1'b0, 1'b0, 1'b0, 32'h0, exp_cc);
                rq = "R9";
            end
            chk(rq, "busy", 32'(busy), 32'(e.busy));
            chk(rq, "rd_valid", 32'(rd_valid), 32'(e.rv));
            chk(e.dn ? "R7" : rq, "done", 32'(done), 32'(e.dn));
            chk("R6", "err", 32'(err), 32'(e.er));
            chk("R8", "cycle_count", 32'(cycle_count), 32'(e.cc));
            if (e.rv) chk("R2", "rd_data", rd_data, e.d);
        end
    end

    // Build the expected cycle sequence for one request.
    task automatic predict(bit rd, int addr, bit il, logic [31:0] wd);
        int w = addr / 4;
        if (rd && (addr % 32 != 0)) begin
            q.push_back(mk(0, 0, 0, 1, 0, pred_cc));
        end else if (!rd && (addr % 4 != 0)) begin
            q.push_back(mk(0, 0, 0, 1, 0, pred_cc));
        end else if (!rd) begin
            ref_mem[w] = wd;
            q.push_back(mk(1, 0, 0, 0, 0, pred_cc));
            q.push_back(mk(1, 0, 0, 0, 0, pred_cc));
            pred_cc = 8'd2;
            q.push_back(mk(0, 0, 1, 0, 0, pred_cc));
        end else begin
            for (int k = 0; k < 8; k++) begin
                if (!il || (k % 4 == 0)) q.push_back(mk(1, 0, 0, 0, 0, pred_cc));
                q.push_back(mk(1, 1, 0, 0, ref_mem[w + k], pred_cc));
            end
            pred_cc = il ? 8'd10 : 8'd16;
            q.push_back(mk(0, 0, 1, 0, 0, pred_cc));
        end
    endtask

    // Issue one request; disturb 1 presents a write while busy, 2 flips the mode.
    task automatic issue(string rq, bit rd, int addr, bit il, logic [31:0] wd, int disturb);
        @(negedge clk); #1;
        cur_req = rq;
        predict(rd, addr, il, wd);
        req_valid = 1'b1; req_rd = rd; req_addr = 31'(addr);
        req_wdata = wd; interleave = il;
        @(posedge clk); #1;
        req_valid = 1'b0;
        if (disturb == 1) begin
            req_valid = 1'b1; req_rd = 1'b0; req_addr = '0; req_wdata = 32'hDEAD_BEEF;
        end else if (disturb == 2) begin
            interleave = !il;
        end
        if (disturb != 0) begin
            repeat (3) @(posedge clk);
            #1;
            req_valid = 1'b0; interleave = il;
        end
        wait (q.size() == 0);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R10", "busy in reset", 32'(busy), 32'h0);
        chk("R10", "done in reset", 32'(done), 32'h0);
        chk("R10", "err in reset", 32'(err), 32'h0);
        chk("R10", "rd_valid in reset", 32'(rd_valid), 32'h0);
        chk("R10", "cycle_count in reset", 32'(cycle_count), 32'h0);
        #1 rst_n = 1'b1;
        run = 1'b1;
        // R5: fill words 0..31 in both modes.
        for (int w = 0; w < 32; w++)
            issue("R5", 1'b0, w * 4, w[0], 32'hA500_0000 ^ (w * 32'h0101_0103), 0);
        // R3 / R4: same block under both timings.
        issue("R3", 1'b1, 0, 1'b1, 0, 0);
        issue("R4", 1'b1, 0, 1'b0, 0, 0);
        issue("R3", 1'b1, 32, 1'b1, 0, 0);
        issue("R4", 1'b1, 64, 1'b0, 0, 0);
        // R9: write presented during a burst is ignored; word 0 checked later.
        issue("R9", 1'b1, 96, 1'b1, 0, 1);
        issue("R9", 1'b1, 0, 1'b0, 0, 0);
        // R11: mode flips mid-burst in both directions.
        issue("R11", 1'b1, 64, 1'b1, 0, 2);
        issue("R11", 1'b1, 32, 1'b0, 0, 2);
        // R6: misaligned read and writes rejected, storage unchanged.
        issue("R6", 1'b1, 16, 1'b1, 0, 0);
        issue("R6", 1'b0, 6, 1'b1, 32'h1111_1111, 0);
        issue("R6", 1'b0, 1, 1'b0, 32'h2222_2222, 0);
        issue("R6", 1'b1, 0, 1'b1, 0, 0);
        // R1 / R2: overwrite then read back.
        issue("R1", 1'b0, 12, 1'b1, 32'h0BAD_CAFE, 0);
        issue("R2", 1'b1, 0, 1'b1, 0, 0);
        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule